// File: doc/BRIEF.md
# SPI Character Display Word Latch

This block is the receiving end of a one-way serial link from an SPI master to a character display controller. While the active-low select is held low, it shifts in bits from the data line, one on each rising edge of the serial clock, most significant bit first. Nothing reaches the display while the word is being shifted in. When select returns high and stays high for a minimum number of local clock cycles, the block checks the transfer. If the last received word is complete and is a write, the block copies that word's display fields into its output register and raises a single load strobe that is one local clock wide.

The serial clock, data and select inputs are treated as asynchronous. All three pass through identical two-stage synchronizers into the local clock domain, so data and clock keep their relative timing. The local clock must run several times faster than the serial clock. A word is 16 bits. Bits [7:0] carry the display byte. Bit 9 selects command (0) or character data (1). Bit 8 marks a read and must be 0 for the word to be forwarded. For example, word 0x0001 clears the screen, and word 0x0200 | c writes character c.

Top module: `lcd_word_latch`

## Requirements
- R1: While select is high, serial clock and data activity shifts no bits, produces no load, and leaves the outputs unchanged.
- R2: While select is low, each rising serial clock edge shifts in exactly one data bit, most significant bit first.
- R3: `lcdData` and `lcdRs` change only in the cycle in which `lcdLoad` is high. At all other times they hold their values, including during shifting.
- R4: A load happens only after select rises and then stays high for MIN_HIGH consecutive synchronized local cycles. Each such high period gives at most one `lcdLoad` pulse, exactly one clock wide.
- R5: A high pulse on select that is shorter than MIN_HIGH cycles is ignored: it gives no load, and the bits received before and after it combine into one word.
- R6: If several complete words arrive during one low period of select, only the last one is forwarded. The earlier ones are lost.
- R7: A transfer whose bit count is zero or is not a multiple of 16 gives no load.
- R8: On a load, `lcdData` equals bits [7:0] of the last word and `lcdRs` equals bit 9 (so 0x0001 gives command 0x01, and 0x0241 gives character 0x41).
- R9: A complete word with bit 8 set is not forwarded: it gives no load and no output change.
- R10: After reset, `lcdLoad`, `lcdData` and `lcdRs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSclk | input | 1 | Serial clock from the master, asynchronous |
| spiMosi | input | 1 | Serial data from the master, asynchronous |
| spiSelN | input | 1 | Active-low select from the master, asynchronous |
| lcdData | output | 8 | Display byte of the last forwarded word |
| lcdRs | output | 1 | Register select of the last forwarded word: 1 for character data, 0 for command |
| lcdLoad | output | 1 | One-cycle strobe that marks new values on lcdData and lcdRs |

## Verification
A wrong bit counter or a wrong shift path never shows up mid-transfer. It appears only at the next qualified rise of select: the load is missing, an extra load appears, or the forwarded byte is wrong. This is visible within a few local cycles after the select edge clears the synchronizer and the minimum-high window. So every transaction in the sweeps ends with a select rise, and the bench compares the outputs and the strobe count in a fixed window after it. A corrupted qualifier on the select-high window shows up as either a load after a glitch or a missing load after a long high period. The glitch cases and the bit-count sweep are aimed at exactly that.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic shiftBit;  // take one synchronized data bit into the shift register
    logic loadOut;   // copy display fields into the output register
  } lcdlStrb_t;

endpackage

// File: rtl/lcdl_sync.sv
module lcdl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= RST_VAL;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/lcdl_ctrl.sv
module lcdl_ctrl
  import lcdl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MIN_HIGH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclkS,
  input  logic      selS,
  input  logic      rwBit,
  output lcdlStrb_t strb
);

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int HI_W  = $clog2(MIN_HIGH + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [HI_W-1:0]  HI_FULL  = HI_W'(MIN_HIGH);
  localparam logic [HI_W-1:0]  HI_FIRE  = HI_W'(MIN_HIGH - 1);

  logic             sclkD;
  logic [HI_W-1:0]  highCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             haveWord;
  logic             sclkRise;
  logic             shiftNow;
  logic             fire;

  assign sclkRise = sclkS & ~sclkD;
  assign shiftNow = sclkRise & ~selS;
  assign fire     = selS & (highCnt == HI_FIRE);

  always_comb begin
    strb.shiftBit = shiftNow;
    strb.loadOut  = fire & haveWord & (bitCnt == '0) & ~rwBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkD    <= 1'b0;
      highCnt  <= '0;
      bitCnt   <= '0;
      haveWord <= 1'b0;
    end else begin
      sclkD <= sclkS;
      if (selS) begin
        if (highCnt != HI_FULL) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
      end
      if (fire) begin
        bitCnt   <= '0;
        haveWord <= 1'b0;
      end else if (shiftNow) begin
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          haveWord <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  AST_BITS_FROZEN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (selS && !fire) |=> $stable(bitCnt) && $stable(haveWord)); // R1

  AST_LOAD_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |=> !haveWord && (bitCnt == '0)); // R7

endmodule

// File: rtl/lcdl_datapath.sv
module lcdl_datapath
  import lcdl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RW_BIT = 8,
  parameter int RS_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdlStrb_t         strb,
  input  logic              mosiS,
  output logic              rwBit,
  output logic [DATA_W-1:0] lcdData,
  output logic              lcdRs,
  output logic              lcdLoad
);

  // Only the low RS_BIT+1 bits of a word reach the display side.
  localparam int SHR_W = RS_BIT + 1;

  logic [SHR_W-1:0] shreg;

  assign rwBit = shreg[RW_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      lcdData <= '0;
      lcdRs   <= 1'b0;
      lcdLoad <= 1'b0;
    end else begin
      if (strb.shiftBit) shreg <= {shreg[SHR_W-2:0], mosiS};
      lcdLoad <= strb.loadOut;
      if (strb.loadOut) begin
        lcdData <= shreg[DATA_W-1:0];
        lcdRs   <= shreg[RS_BIT];
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lcdLoad |-> $stable(lcdData) && $stable(lcdRs)); // R3

  AST_LOAD_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    lcdLoad |=> !lcdLoad); // R4

endmodule

// File: rtl/lcd_word_latch.sv
module lcd_word_latch
  import lcdl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 8,
  parameter int RW_BIT = 8,
  parameter int RS_BIT = 9,
  parameter int MIN_HIGH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  logic              spiSelN,
  output logic [DATA_W-1:0] lcdData,
  output logic              lcdRs,
  output logic              lcdLoad
);

  lcdlStrb_t  strb;
  logic [2:0] syncVec;
  logic       sclkS;
  logic       mosiS;
  logic       selS;
  logic       rwBit;

  lcdl_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b100)
  ) uSync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({spiSelN, spiMosi, spiSclk}),
    .syncOut(syncVec)
  );

  assign sclkS = syncVec[0];
  assign mosiS = syncVec[1];
  assign selS  = syncVec[2];

  lcdl_ctrl #(
    .WORD_W(WORD_W),
    .MIN_HIGH(MIN_HIGH)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .sclkS(sclkS),
    .selS(selS),
    .rwBit(rwBit),
    .strb(strb)
  );

  lcdl_datapath #(
    .DATA_W(DATA_W),
    .RW_BIT(RW_BIT),
    .RS_BIT(RS_BIT)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .mosiS(mosiS),
    .rwBit(rwBit),
    .lcdData(lcdData),
    .lcdRs(lcdRs),
    .lcdLoad(lcdLoad)
  );

  AST_NO_SHIFT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    selS |-> !strb.shiftBit); // R1

  AST_LOAD_WITH_SEL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    lcdLoad |-> selS && $past(selS)); // R4

endmodule

// File: tb/sim_lcd_word_latch.sv
module sim_lcd_word_latch;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF = 4;
  localparam int OBS_WIN = 24;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiSclk = 1'b0;
  logic       spiMosi = 1'b0;
  logic       spiSelN = 1'b1;
  logic [7:0] lcdData;
  logic       lcdRs;
  logic       lcdLoad;

  int         nRun = 0;
  int         nFail = 0;
  logic [7:0] lastD = 8'h00;
  logic       lastRs = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_word_latch u0 (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiSelN(spiSelN), .lcdData(lcdData), .lcdRs(lcdRs), .lcdLoad(lcdLoad)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) spiMosi = v[i];
      repeat (SCLK_HALF) @(negedge clk);
      spiSclk = 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic selDown();
    @(negedge clk) spiSelN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic selUp(output int pulses, output logic [7:0] d, output logic rs);
    @(negedge clk) spiSelN = 1'b1;
    pulses = 0; d = lcdData; rs = lcdRs;
    repeat (OBS_WIN) begin
      @(negedge clk);
      if (lcdLoad) begin pulses++; d = lcdData; rs = lcdRs; end
    end
  endtask

  // One transaction; expected result computed from R7, R8, R9.
  task automatic runTxn(input logic [63:0] v, input int n, input string req);
    int pulses; logic [7:0] d; logic rs; bit expLoad;
    expLoad = (n > 0) && (n % 16 == 0) && !v[8];
    selDown();
    shiftBits(v, n);
    check(lcdData == lastD && lcdRs == lastRs, {req, " R3 hold mid-shift"}, lcdData, lastD);
    selUp(pulses, d, rs);
    if (expLoad) begin
      lastD = v[7:0]; lastRs = v[9];
      check(pulses == 1, {req, " R4 one pulse"}, pulses, 1);
    end else begin
      check(pulses == 0, {req, " no load"}, pulses, 0);
    end
    check(d == lastD, {req, " R8 data"}, d, lastD);
    check(rs == lastRs, {req, " R8 rs"}, rs, lastRs);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    int pulses; logic [7:0] d; logic rs;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(lcdLoad == 1'b0, "R10 load", lcdLoad, 0);
    check(lcdData == 8'h00, "R10 data", lcdData, 0);
    check(lcdRs == 1'b0, "R10 rs", lcdRs, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R8 clear-screen command, then one character
    runTxn(64'h0001, 16, "R8 clear");
    runTxn(64'h0241, 16, "R8 char");

    // R1 activity while select is high: no load, outputs held
    pulses = 0;
    fork
      shiftBits(64'h03FF, 16);
      repeat (16 * 2 * SCLK_HALF + 4) begin @(negedge clk); if (lcdLoad) pulses++; end
    join
    check(pulses == 0, "R1 no load while high", pulses, 0);
    check(lcdData == lastD && lcdRs == lastRs, "R1 outputs held", lcdData, lastD);
    runTxn(64'h0255, 16, "R1 next word clean");

    // R2 R8 sweep of every character byte
    for (int c = 0; c < 256; c++) runTxn(64'h0200 | 64'(c), 16, "R2 char sweep");
    // R8 command sweep over a few bytes
    for (int c = 0; c < 256; c += 17) runTxn(64'(c), 16, "R8 cmd sweep");

    // R6 two and three words in one low period
    runTxn(64'h0255_0233, 32, "R6 two words");
    runTxn(64'h0211_0001_0266, 48, "R6 three words");

    // R7 bit count sweep
    for (int n = 0; n <= 40; n++) runTxn(64'hA5C3_0212_0247, n, "R7 count sweep");

    // R9 read words not forwarded
    for (int c = 0; c < 256; c += 51) runTxn(64'h0100 | 64'(c), 16, "R9 read word");
    runTxn(64'h0341, 16, "R9 read data word");

    // R5 glitch between two halves of a word
    selDown();
    shiftBits(64'h02, 8);
    @(negedge clk) spiSelN = 1'b1;
    @(negedge clk) spiSelN = 1'b0;
    pulses = 0;
    repeat (12) begin @(negedge clk); if (lcdLoad) pulses++; end
    check(pulses == 0, "R5 glitch no load", pulses, 0);
    shiftBits(64'hC3, 8);
    selUp(pulses, d, rs);
    lastD = 8'hC3; lastRs = 1'b1;
    check(pulses == 1, "R5 merged word loads", pulses, 1);
    check(d == 8'hC3 && rs == 1'b1, "R5 merged data", d, 8'hC3);

    // R5 glitch after a complete word, then proper rise
    selDown();
    shiftBits(64'h027E, 16);
    @(negedge clk) spiSelN = 1'b1;
    @(negedge clk) spiSelN = 1'b0;
    pulses = 0;
    repeat (12) begin @(negedge clk); if (lcdLoad) pulses++; end
    check(pulses == 0, "R5 glitch after word", pulses, 0);
    check(lcdData == lastD, "R5 output held", lcdData, lastD);
    selUp(pulses, d, rs);
    lastD = 8'h7E; lastRs = 1'b1;
    check(pulses == 1 && d == 8'h7E, "R4 load after full high", d, 8'h7E);

    finishRun();
  end

endmodule